// File: doc/BRIEF.md
# UART Transmit Framer

This block turns characters offered by an external transmit queue into asynchronous serial frames on a single output line. The frame is built as one low start bit, the data bits least significant first, an optional parity bit, and one or two high stop bits. The line rests high between frames. An 8-bit line-control word sets the format. The word is captured at the moment a character is taken from the queue, so a change applies from the next character onward.

Bit timing comes from an internal 16x oversampling tick generator. It has a 16-bit integer divisor and a 6-bit fractional divisor. The fractional part is accumulated on every tick, and each carry out of the accumulator stretches the next tick period by one clock. A busy output tells software when the line has fully drained. A level-held break bit forces the line low for as long as it is set, and software is expected to hold it for at least two frame times.

Top module: `uart_tx_framer`

## Requirements
- R1: During and immediately after reset, `txd_o` is 1. While `fifo_empty_i` is 1, `busy_o` and `fifo_pop_o` are 0.
- R2: A frame starts with one low start bit, followed by the data bits least significant bit first. The line is high before and after every frame. Each bit lasts 16 ticks.
- R3: `ctrl_i[6:5]` selects the word length: 00 gives 5 bits, 01 gives 6, 10 gives 7 and 11 gives 8. Data bits above the selected length are not sent.
- R4: When `ctrl_i[3]` is 1 the frame ends with two stop bits; when it is 0 the frame ends with one.
- R5: `ctrl_i[1]` enables a parity bit after the data. With `ctrl_i[7]`=0, `ctrl_i[2]`=1 selects even parity (data ones plus parity bit is even) and `ctrl_i[2]`=0 selects odd parity.
- R6: With `ctrl_i[1]`=1 and `ctrl_i[7]`=1, the parity bit is the constant inverse of `ctrl_i[2]`. Control 0x82 sends a 1 and 0x86 sends a 0, regardless of the data.
- R7: `busy_o` is 1 while the queue is non-empty or a frame is in progress, including its final stop bit. It stays continuously high across back-to-back characters. For divisor 1, a frame of N bits keeps `busy_o` high for exactly 16·N clocks after the pop.
- R8: While `ctrl_i[0]` (break) is 1, `txd_o` is driven low from the next clock onward. When break is cleared, the line returns to its normal value on the next clock.
- R9: The line-control word is captured when a character is popped. A change during a frame does not alter that frame's length or content.
- R10: One tick occurs every `div_int_i` clocks, plus one extra clock whenever the 6-bit accumulator of `div_frac_i` overflows. A data bit therefore lasts 16·`div_int_i` + 16·`div_frac_i`/64 clocks when that value is whole. `div_int_i` must be at least 1.
- R11: `fifo_pop_o` is 1 for exactly one clock per character taken. It is asserted only when the framer is idle and `fifo_empty_i` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctrl_i | input | 8 | Line-control word: [0] break, [1] parity enable, [2] even/constant select, [3] two stop bits, [6:5] word length, [7] constant parity |
| div_int_i | input | 16 | Integer tick divisor (at least 1) |
| div_frac_i | input | 6 | Fractional tick divisor in 64ths |
| fifo_empty_i | input | 1 | Transmit queue is empty |
| fifo_data_i | input | 8 | Character at the head of the queue |
| fifo_pop_o | output | 1 | Takes the head character this clock |
| txd_o | output | 1 | Serial output line, registered |
| busy_o | output | 1 | Queue non-empty or frame still on the line |

## Verification
The bench samples every bit of each frame at mid-bit for all four word lengths, both stop counts and all parity kinds. A design that sent bits above the word length, lost the second stop bit, or inverted the even/odd sense would show a wrong bit at a known position. The busy window is counted clock by clock, so a flag that drops when the last data bit leaves, or that dips between back-to-back characters, gives a count that differs from 16·N. The control word is changed in the middle of a frame; a framer that reads it live would shorten that frame. Bit widths are measured with integer and fractional divisors, and an accumulator that never carries would give bits that are too short.

// File: rtl/uart_tx_pkg.sv
package uart_tx_pkg;

  localparam int CHAR_W = 8;
  localparam int IDX_W  = $clog2(CHAR_W);

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_PAR,
    ST_STOP
  } tx_state_e;

  // Frame format captured at the pop of a character
  typedef struct packed {
    logic [IDX_W-1:0] last_idx;  // index of the final data bit
    logic             two_stop;
    logic             par_en;
    logic             par_val;
  } tx_fmt_t;

  function automatic logic [CHAR_W-1:0] len_mask(input logic [1:0] len_sel);
    logic [CHAR_W-1:0] m;
    for (int i = 0; i < CHAR_W; i++) begin
      m[i] = (i < (int'(len_sel) + 5));
    end
    return m;
  endfunction

  function automatic tx_fmt_t decode_fmt(input logic [7:0] ctrl,
                                         input logic [CHAR_W-1:0] data);
    tx_fmt_t f;
    logic [CHAR_W-1:0] kept;
    kept       = data & len_mask(ctrl[6:5]);
    f.last_idx = IDX_W'(ctrl[6:5]) + IDX_W'(4);
    f.two_stop = ctrl[3];
    f.par_en   = ctrl[1];
    if (ctrl[7]) f.par_val = ~ctrl[2];
    else         f.par_val = ctrl[2] ? (^kept) : ~(^kept);
    return f;
  endfunction

endpackage

// File: rtl/uart_tx_baud.sv
module uart_tx_baud #(
  parameter int INT_W  = 16,
  parameter int FRAC_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [INT_W-1:0]  div_int,
  input  logic [FRAC_W-1:0] div_frac,
  output logic              tick_o
);

  logic [INT_W-1:0]  cnt_q, cnt_d;
  logic [FRAC_W-1:0] acc_q, acc_d;
  logic [FRAC_W:0]   sum;

  assign tick_o = (cnt_q == '0);
  assign sum    = {1'b0, acc_q} + {1'b0, div_frac};

  always_comb begin
    cnt_d = cnt_q;
    acc_d = acc_q;
    if (tick_o) begin
      acc_d = sum[FRAC_W-1:0];
      cnt_d = div_int - INT_W'(1) + INT_W'(sum[FRAC_W]);
    end else begin
      cnt_d = cnt_q - INT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      acc_q <= '0;
    end else begin
      cnt_q <= cnt_d;
      acc_q <= acc_d;
    end
  end

endmodule

// File: rtl/uart_tx_frame.sv
module uart_tx_frame
  import uart_tx_pkg::*;
#(
  parameter int OSR = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic [7:0]        ctrl,
  input  logic              fifo_empty,
  input  logic [CHAR_W-1:0] fifo_data,
  output logic              pop_o,
  output logic              line_o,
  output logic              active_o
);

  localparam int SUB_W = $clog2(OSR);

  tx_state_e         state_q, state_d;
  logic [SUB_W-1:0]  sub_q, sub_d;
  logic [IDX_W-1:0]  idx_q, idx_d;
  logic [CHAR_W-1:0] shr_q, shr_d;
  tx_fmt_t           fmt_q, fmt_d;
  logic              stop2_q, stop2_d;
  logic              bit_end;

  assign bit_end  = tick && (sub_q == SUB_W'(OSR - 1));
  assign pop_o    = (state_q == ST_IDLE) && !fifo_empty;
  assign active_o = (state_q != ST_IDLE);

  always_comb begin
    unique case (state_q)
      ST_START: line_o = 1'b0;
      ST_DATA:  line_o = shr_q[0];
      ST_PAR:   line_o = fmt_q.par_val;
      default:  line_o = 1'b1;
    endcase
  end

  always_comb begin
    state_d = state_q;
    sub_d   = tick ? sub_q + SUB_W'(1) : sub_q;
    idx_d   = idx_q;
    shr_d   = shr_q;
    fmt_d   = fmt_q;
    stop2_d = stop2_q;
    unique case (state_q)
      ST_IDLE: begin
        if (pop_o) begin
          state_d = ST_START;
          sub_d   = '0;
          shr_d   = fifo_data;
          fmt_d   = decode_fmt(ctrl, fifo_data);
        end
      end
      ST_START: begin
        if (bit_end) begin
          state_d = ST_DATA;
          idx_d   = '0;
        end
      end
      ST_DATA: begin
        if (bit_end) begin
          shr_d = shr_q >> 1;
          if (idx_q == fmt_q.last_idx) begin
            state_d = fmt_q.par_en ? ST_PAR : ST_STOP;
            stop2_d = 1'b0;
          end else begin
            idx_d = idx_q + IDX_W'(1);
          end
        end
      end
      ST_PAR: begin
        if (bit_end) begin
          state_d = ST_STOP;
          stop2_d = 1'b0;
        end
      end
      ST_STOP: begin
        if (bit_end) begin
          if (fmt_q.two_stop && !stop2_q) stop2_d = 1'b1;
          else                            state_d = ST_IDLE;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      sub_q   <= '0;
      idx_q   <= '0;
      shr_q   <= '0;
      fmt_q   <= '0;
      stop2_q <= 1'b0;
    end else begin
      state_q <= state_d;
      sub_q   <= sub_d;
      idx_q   <= idx_d;
      shr_q   <= shr_d;
      fmt_q   <= fmt_d;
      stop2_q <= stop2_d;
    end
  end

endmodule

// File: rtl/uart_tx_line.sv
module uart_tx_line (
  input  logic clk,
  input  logic rst_n,
  input  logic brk,
  input  logic line_i,
  output logic txd_o
);

  logic txd_d;

  assign txd_d = brk ? 1'b0 : line_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) txd_o <= 1'b1;
    else        txd_o <= txd_d;
  end

endmodule

// File: rtl/uart_tx_framer.sv
module uart_tx_framer
  import uart_tx_pkg::*;
#(
  parameter int DIV_INT_W  = 16,
  parameter int DIV_FRAC_W = 6,
  parameter int OSR        = 16
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [7:0]            ctrl_i,
  input  logic [DIV_INT_W-1:0]  div_int_i,
  input  logic [DIV_FRAC_W-1:0] div_frac_i,
  input  logic                  fifo_empty_i,
  input  logic [CHAR_W-1:0]     fifo_data_i,
  output logic                  fifo_pop_o,
  output logic                  txd_o,
  output logic                  busy_o
);

  logic tick;
  logic line;
  logic active;

  uart_tx_baud #(.INT_W(DIV_INT_W), .FRAC_W(DIV_FRAC_W)) u_baud (
    .clk      (clk),
    .rst_n    (rst_n),
    .div_int  (div_int_i),
    .div_frac (div_frac_i),
    .tick_o   (tick)
  );

  uart_tx_frame #(.OSR(OSR)) u_frame (
    .clk        (clk),
    .rst_n      (rst_n),
    .tick       (tick),
    .ctrl       (ctrl_i),
    .fifo_empty (fifo_empty_i),
    .fifo_data  (fifo_data_i),
    .pop_o      (fifo_pop_o),
    .line_o     (line),
    .active_o   (active)
  );

  uart_tx_line u_line (
    .clk    (clk),
    .rst_n  (rst_n),
    .brk    (ctrl_i[0]),
    .line_i (line),
    .txd_o  (txd_o)
  );

  assign busy_o = active || !fifo_empty_i;

endmodule

// File: rtl/uart_tx_framer_chk.sv
module uart_tx_framer_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [7:0] ctrl_i,
  input logic       fifo_empty_i,
  input logic       fifo_pop_o,
  input logic       txd_o,
  input logic       busy_o
);

  logic seen1, seen2;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seen1 <= 1'b0;
      seen2 <= 1'b0;
    end else begin
      seen1 <= 1'b1;
      seen2 <= seen1;
    end
  end

  // R8
  brk_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    seen1 && $past(ctrl_i[0]) |-> !txd_o);

  // R7
  idle_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    seen1 && !busy_o && !$past(busy_o) && !ctrl_i[0] && !$past(ctrl_i[0]) |-> txd_o);

  // R11
  pop_needs_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_pop_o |-> !fifo_empty_i);

  // R11
  single_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_pop_o |=> !fifo_pop_o);

  // R7
  busy_after_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_pop_o |=> busy_o);

  // R7
  busy_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    seen1 && $fell(busy_o) |-> fifo_empty_i);

  // R2
  start_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    seen2 && $past(fifo_pop_o, 2) && !$past(ctrl_i[0]) |-> !txd_o);

endmodule

bind uart_tx_framer uart_tx_framer_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .ctrl_i       (ctrl_i),
  .fifo_empty_i (fifo_empty_i),
  .fifo_pop_o   (fifo_pop_o),
  .txd_o        (txd_o),
  .busy_o       (busy_o)
);

// File: tb/uart_tx_framer_test.sv
module uart_tx_framer_test;

  logic        clk;
  logic        rst_n;
  logic [7:0]  ctrl_i;
  logic [15:0] div_int_i;
  logic [5:0]  div_frac_i;
  logic        fifo_empty_i;
  logic [7:0]  fifo_data_i;
  logic        fifo_pop_o;
  logic        txd_o;
  logic        busy_o;

  int n_chk;
  int n_bad;

  uart_tx_framer uut (
    .clk          (clk),
    .rst_n        (rst_n),
    .ctrl_i       (ctrl_i),
    .div_int_i    (div_int_i),
    .div_frac_i   (div_frac_i),
    .fifo_empty_i (fifo_empty_i),
    .fifo_data_i  (fifo_data_i),
    .fifo_pop_o   (fifo_pop_o),
    .txd_o        (txd_o),
    .busy_o       (busy_o)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic check(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d (0x%0h) expected %0d (0x%0h)", tag, act, act, exp, exp);
    end
  endtask

  function automatic int frame_len(input logic [7:0] c);
    return 1 + (int'(c[6:5]) + 5) + int'(c[1]) + (c[3] ? 2 : 1);
  endfunction

  // Expected frame, bit 0 first on the line; unused upper bits read as idle 1
  function automatic logic [15:0] frame_exp(input logic [7:0] c, input logic [7:0] d);
    logic [15:0] f;
    int nb, ones, p;
    f    = '1;
    nb   = int'(c[6:5]) + 5;
    ones = 0;
    f[0] = 1'b0;
    for (int i = 0; i < nb; i++) begin
      f[1+i] = d[i];
      if (d[i]) ones++;
    end
    p = 1 + nb;
    if (c[1]) begin
      if (c[7])      f[p] = ~c[2];
      else if (c[2]) f[p] = (ones % 2 == 1);
      else           f[p] = (ones % 2 == 0);
    end
    return f;
  endfunction

  // One character: capture mid-bit samples and count busy clocks
  task automatic send(input logic [7:0] c, input logic [7:0] d, input bit chg,
                      input logic [7:0] c2, output logic [15:0] cap, output int busy_n);
    @(negedge clk);
    ctrl_i       = c;
    fifo_data_i  = d;
    fifo_empty_i = 1'b0;
    #1 check("R11 pop when idle with data", int'(fifo_pop_o), 1);
    @(posedge clk);
    busy_n = 0;
    cap    = '1;
    for (int k = 0; k < 1000; k++) begin
      @(negedge clk);
      if (k == 0) fifo_empty_i = 1'b1;
      if (k == 1) check("R11 pop lasts one clock", int'(fifo_pop_o), 0);
      if (chg && k == 40) ctrl_i = c2;
      if (k >= 8 && ((k - 8) % 16) == 0 && ((k - 8) / 16) < 16) cap[(k - 8) / 16] = txd_o;
      if (busy_o) busy_n++;
      else break;
    end
    @(negedge clk);
    check("R2 line high after frame", int'(txd_o), 1);
  endtask

  task automatic t_format(input string tag, input logic [7:0] c, input logic [7:0] d);
    logic [15:0] cap;
    int bn;
    send(c, d, 1'b0, 8'h00, cap, bn);
    check({tag, " frame bits"}, int'(cap), int'(frame_exp(c, d)));
    check({"R7 busy span ", tag}, bn, 16 * frame_len(c));
  endtask

  task automatic t_reset;
    rst_n        = 1'b0;
    ctrl_i       = 8'h60;
    div_int_i    = 16'd1;
    div_frac_i   = 6'd0;
    fifo_empty_i = 1'b1;
    fifo_data_i  = 8'h00;
    repeat (3) @(negedge clk);
    check("R1 txd in reset", int'(txd_o), 1);
    check("R1 busy in reset", int'(busy_o), 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check("R1 txd after reset", int'(txd_o), 1);
    check("R1 busy idle", int'(busy_o), 0);
    check("R1 no pop when empty", int'(fifo_pop_o), 0);
  endtask

  task automatic t_midframe;
    logic [15:0] cap;
    int bn;
    send(8'h60, 8'h3C, 1'b1, 8'h0E, cap, bn);
    check("R9 frame kept old format", int'(cap), int'(frame_exp(8'h60, 8'h3C)));
    check("R9 busy span kept", bn, 160);
    @(negedge clk);
    ctrl_i = 8'h60;
  endtask

  task automatic t_break;
    int lows;
    @(negedge clk);
    ctrl_i = 8'h61;
    @(negedge clk);
    lows = 0;
    for (int k = 0; k < 40; k++) begin
      @(negedge clk);
      if (!txd_o) lows++;
    end
    check("R8 line held low under break", lows, 40);
    check("R8 break not busy", int'(busy_o), 0);
    ctrl_i = 8'h60;
    @(negedge clk);
    check("R8 line released", int'(txd_o), 1);
  endtask

  task automatic t_back2back;
    int bn, pops;
    bit got2, drop;
    @(negedge clk);
    ctrl_i       = 8'h60;
    fifo_data_i  = 8'h11;
    fifo_empty_i = 1'b0;
    @(posedge clk);
    bn = 0; pops = 0; got2 = 1'b0; drop = 1'b0;
    for (int k = 0; k < 2000; k++) begin
      @(negedge clk);
      if (k == 0) fifo_data_i = 8'h22;
      if (got2) fifo_empty_i = 1'b1;
      if (fifo_pop_o) begin
        pops++;
        got2 = 1'b1;
      end
      if (busy_o) bn++;
      else begin
        drop = 1'b1;
        break;
      end
    end
    check("R11 second pop count", pops, 1);
    check("R7 busy continuous over two chars", bn, 321);
    check("R7 busy falls at end", int'(drop), 1);
  endtask

  task automatic t_bitwidth(input string tag, input logic [15:0] di,
                            input logic [5:0] df, input int exp);
    int ph, run;
    @(negedge clk);
    div_int_i    = di;
    div_frac_i   = df;
    ctrl_i       = 8'h60;
    fifo_data_i  = 8'h55;
    fifo_empty_i = 1'b0;
    @(posedge clk);
    ph = 0; run = 0;
    for (int k = 0; k < 5000; k++) begin
      @(negedge clk);
      if (k == 0) fifo_empty_i = 1'b1;
      if (ph == 0 && !txd_o) ph = 1;
      else if (ph == 1 && txd_o) ph = 2;
      else if (ph == 2 && !txd_o) begin ph = 3; run = 1; end
      else if (ph == 3) begin
        if (!txd_o) run++;
        else break;
      end
    end
    check({"R10 bit width ", tag}, run, exp);
    for (int k = 0; k < 5000 && busy_o; k++) @(negedge clk);
    div_int_i  = 16'd1;
    div_frac_i = 6'd0;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    n_chk = 0;
    n_bad = 0;
    fork
      begin
        t_reset();
        t_format("R2 8-bit", 8'h60, 8'hA5);
        t_format("R3 5-bit", 8'h00, 8'hFF);
        t_format("R3 6-bit", 8'h20, 8'h2A);
        t_format("R3 7-bit", 8'h40, 8'hDB);
        t_format("R4 two stop", 8'h68, 8'h96);
        t_format("R4 5-bit two stop", 8'h08, 8'h13);
        t_format("R5 even", 8'h66, 8'h07);
        t_format("R5 odd", 8'h62, 8'h07);
        t_format("R5 even 6-bit masked", 8'h26, 8'hC1);
        t_format("R6 constant one", 8'hE2, 8'h00);
        t_format("R6 constant zero", 8'hE6, 8'hFF);
        t_midframe();
        t_break();
        t_back2back();
        t_bitwidth("int 3", 16'd3, 6'd0, 48);
        t_bitwidth("frac 1.5", 16'd1, 6'd32, 24);
        t_bitwidth("frac 2.25", 16'd2, 6'd16, 36);
      end
      begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule